// File: doc/BRIEF.md
# Indirect Configuration Port Decoder

This block sits on the I/O access path of a processor and sorts each 16-bit port access into one of three destinations. One port holds a 32-bit address register that software loads to pick a configuration location. Four consecutive data ports then reach that location, provided the register's enable bit is set. Every other port is passed on as a plain I/O address, tagged with the I/O space prefix.

The decode is combinational, so the routing outputs follow the inputs in the same cycle. The only state is the address register. A 4-byte write to the register port loads it on the next rising clock. A read of the register port returns the register's current value on the read data output. A data-port access made while the enable bit is clear is not sent anywhere; the decoder reports it as unclaimed. A port value with any bit set above bit 15 is flagged as malformed and is not routed.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address register reads as zero: a 4-byte read of port 0xCF8 returns rdata_o = 0.
- R2: Only an access of size 4 to port 0xCF8 selects the register target (tgt_o = 2'd1). An access of any other size to 0xCF8 is routed as plain I/O.
- R3: A 4-byte write to port 0xCF8 loads wdata_i into the register at the next rising clock. A read of 0xCF8 returns the register value on rdata_o. A write of any other size to 0xCF8, and any access to another port, leaves the register unchanged.
- R4: An access to any port from 0xCFC to 0xCFF, made while register bit 31 is set, has target config (tgt_o = 2'd2). Its addr_o equals {1'b0, reg[30:2], port[1:0]}, zero-extended to ADDR_W bits.
- R5: An access to 0xCFC to 0xCFF while register bit 31 is clear sets unclaimed_o = 1 and tgt_o = 2'd0 (none).
- R6: Any other port has target I/O (tgt_o = 2'd3) with addr_o = IO_PREFIX | port.
- R7: If any port_i bit above bit 15 is set, bad_port_o = 1, tgt_o = 2'd0 and the register is not written.
- R8: With valid_i low, tgt_o = 2'd0, unclaimed_o = 0 and the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access present this cycle |
| port_i | input | 32 | Port number (only the low 16 bits are legal) |
| size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| write_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| tgt_o | output | 2 | 0 none, 1 register, 2 config, 3 I/O |
| addr_o | output | 40 | Routed address for config or I/O targets |
| rdata_o | output | 32 | Register value, returned for register reads |
| unclaimed_o | output | 1 | Data-port access with the enable bit clear |
| bad_port_o | output | 1 | Port value above 16 bits |

## Verification
The address register is the only state, and it shows up at the ports in two ways. Its value appears on rdata_o during any register read. Its enable bit and its bits 30 to 2 show up during data-port accesses, through tgt_o, unclaimed_o and the config address. A corrupted load or a write that should have been ignored therefore becomes visible one cycle later, at the next register read or data access. The bench makes that read or access straight after each write it issues.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_CFG  = 2'd2,
    TGT_IO   = 2'd3
  } tgt_e;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/port_classify.sv
module port_classify #(
  parameter int          PORT_IN_W = 32,
  parameter int          PORT_W    = 16,
  parameter logic [15:0] REG_PORT  = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input  logic [PORT_IN_W-1:0] port_i,
  input  logic [2:0]           size_i,
  output logic                 bad_o,
  output logic                 is_reg_o,
  output logic                 is_data_o
);
  logic [PORT_W-1:0] p;
  assign p     = port_i[PORT_W-1:0];
  assign bad_o = |port_i[PORT_IN_W-1:PORT_W];

  always_comb begin
    is_reg_o  = !bad_o && (p == REG_PORT[PORT_W-1:0]) && (size_i == 3'd4);
    is_data_o = !bad_o && (p[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int                 PORT_IN_W = 32,
  parameter int                 PORT_W    = 16,
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 40,
  parameter logic [ADDR_W-1:0]  IO_PREFIX = 40'h80_0000_0000,
  parameter logic [ADDR_W-1:0]  CFG_PREFIX = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [PORT_IN_W-1:0] port_i,
  input  logic [2:0]           size_i,
  input  logic                 write_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [1:0]           tgt_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 unclaimed_o,
  output logic                 bad_port_o
);
  localparam int EN_BIT = DATA_W - 1;

  logic              bad, is_reg, is_data, reg_we;
  logic [DATA_W-1:0] cfg_q;

  port_classify #(.PORT_IN_W(PORT_IN_W), .PORT_W(PORT_W)) u_cls (
    .port_i   (port_i),
    .size_i   (size_i),
    .bad_o    (bad),
    .is_reg_o (is_reg),
    .is_data_o(is_data)
  );

  assign reg_we = valid_i && is_reg && write_i;

  cfg_addr_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (reg_we),
    .d_i   (wdata_i),
    .q_o   (cfg_q)
  );

  assign rdata_o    = cfg_q;
  assign bad_port_o = valid_i && bad;

  always_comb begin
    tgt_o       = TGT_NONE;
    addr_o      = '0;
    unclaimed_o = 1'b0;
    if (valid_i && !bad) begin
      if (is_reg) begin
        tgt_o = TGT_REG;
      end else if (is_data) begin
        if (cfg_q[EN_BIT]) begin
          tgt_o  = TGT_CFG;
          addr_o = CFG_PREFIX | ADDR_W'({cfg_q[EN_BIT-1:2], port_i[1:0]});
        end else begin
          unclaimed_o = 1'b1;
        end
      end else begin
        tgt_o  = TGT_IO;
        addr_o = IO_PREFIX | ADDR_W'(port_i[PORT_W-1:0]);
      end
    end
  end

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> tgt_o == TGT_NONE && !unclaimed_o);
  p_bad_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_port_o |=> $stable(rdata_o));
  p_unclaimed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unclaimed_o |-> !rdata_o[EN_BIT] && tgt_o == TGT_NONE);
  p_cfg_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_o == TGT_CFG |-> rdata_o[EN_BIT]);
endmodule

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] IOP = 40'h80_0000_0000;

  logic        clk = 0, rst_ni = 0, valid = 0, write = 0;
  logic [31:0] port = 0, wdata = 0;
  logic [2:0]  size = 0;
  logic [1:0]  tgt;
  logic [39:0] addr;
  logic [31:0] rdata;
  logic        unclaimed, bad;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .port_i(port),
    .size_i(size), .write_i(write), .wdata_i(wdata), .tgt_o(tgt),
    .addr_o(addr), .rdata_o(rdata), .unclaimed_o(unclaimed), .bad_port_o(bad)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, sample before posedge
  task automatic drive(logic v, logic [31:0] p, logic [2:0] s, logic w, logic [31:0] d);
    @(negedge clk);
    valid = v; port = p; size = s; write = w; wdata = d;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic rd_reg(string req, logic [31:0] exp);
    drive(1, 32'hCF8, 4, 0, 0);
    chk(req, {62'd0, tgt}, 64'd1);
    chk(req, {32'd0, rdata}, {32'd0, exp});
  endtask

  task automatic t_reset();
    rd_reg("R1", 32'h0);
  endtask

  task automatic t_reg_write();
    drive(1, 32'hCF8, 4, 1, 32'h8000_1234);
    chk("R2", {62'd0, tgt}, 64'd1);
    rd_reg("R3", 32'h8000_1234);
    drive(1, 32'hCF8, 2, 1, 32'h0);
    chk("R2", {62'd0, tgt}, 64'd3);
    chk("R2", {24'd0, addr}, {24'd0, IOP | 40'hCF8});
    rd_reg("R3", 32'h8000_1234);
    drive(1, 32'h80, 4, 1, 32'h0);
    rd_reg("R3", 32'h8000_1234);
  endtask

  task automatic t_cfg_data();
    drive(1, 32'hCF8, 4, 1, 32'h8012_3458);
    for (int i = 0; i < 4; i++) begin
      drive(1, 32'hCFC + i, 1, 0, 0);
      chk("R4", {62'd0, tgt}, 64'd2);
      chk("R4", {24'd0, addr}, {24'd0, 8'd0, 32'h0012_3458 | i});
    end
  endtask

  task automatic t_unclaimed();
    drive(1, 32'hCF8, 4, 1, 32'h7FFF_FFFC);
    drive(1, 32'hCFE, 2, 1, 32'h1);
    chk("R5", {63'd0, unclaimed}, 64'd1);
    chk("R5", {62'd0, tgt}, 64'd0);
  endtask

  task automatic t_io();
    drive(1, 32'h0060, 1, 0, 0);
    chk("R6", {62'd0, tgt}, 64'd3);
    chk("R6", {24'd0, addr}, {24'd0, IOP | 40'h60});
    drive(1, 32'hCFB, 4, 0, 0);
    chk("R6", {24'd0, addr}, {24'd0, IOP | 40'hCFB});
  endtask

  task automatic t_bad();
    drive(1, 32'h0001_0CF8, 4, 1, 32'hDEAD_BEEF);
    chk("R7", {63'd0, bad}, 64'd1);
    chk("R7", {62'd0, tgt}, 64'd0);
    rd_reg("R7", 32'h7FFF_FFFC);
  endtask

  task automatic t_idle();
    @(negedge clk);
    valid = 0; port = 32'hCF8; size = 4; write = 1; wdata = 32'h1111_1111;
    #1;
    chk("R8", {62'd0, tgt}, 64'd0);
    chk("R8", {63'd0, unclaimed}, 64'd0);
    rd_reg("R8", 32'h7FFF_FFFC);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1;
        t_reset();
        t_reg_write();
        t_cfg_data();
        t_unclaimed();
        t_io();
        t_bad();
        t_idle();
        idle();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule